// File: doc/BRIEF.md
# Signal-Processor Bus Glue with I/O Expander and Interrupt Router

This block sits on the external bus of a signal processor and supplies the slow control functions the processor does not have itself. From the I/O-space select, the top address bit and address bits 7 to 3, it decodes active-low chip strobes for the board's peripherals. It also derives separate flash read and flash write strobes. Bits 2 to 0 are left out of the decode so that each peripheral can use them to pick its internal registers. Bits 14 to 8 are ignored as well.

Three registers inside the block sit in the same I/O decode. An 8-bit general-purpose output register drives external control lines, and its three low bits serve as the flash program-page select. A read-only input port places eight status lines on the low data byte through tri-state drivers. A 12-bit routing register assigns any of eight external active-low interrupt sources to each of the processor's four interrupt pins. Each routed interrupt passes through a two-flop synchroniser.

Register writes are handled by a two-state write tracker. **WR_IDLE** moves to **WR_HOLD** when an I/O write strobe hits a register slot, and that transition commits the write. **WR_HOLD** returns to **WR_IDLE** once the write strobe or the I/O select is released. As a result, one held strobe performs exactly one write.

Top module: `dsp_bus_glue`

## Requirements
- R1: `cs_n[i]` is low exactly when `io_sel_n` is low, `addr[15]` is 1 and `addr[7:3]` equals i (i = 0..3). Address bits 14:8 and 2:0 have no effect. The strobe responds combinationally.
- R2: `flash_rd_n` is low exactly when `cs_n[0]` would be low and `rd_n` is low. `flash_wr_n` is low exactly when `cs_n[0]` would be low and `wr_n` is low.
- R3: While `io_sel_n` is high, every chip strobe and both flash strobes stay high, whatever the address and read/write lines do.
- R4: An I/O write (`io_sel_n`=0, `wr_n`=0) with `addr[15]`=1 and `addr[7:3]`=16 loads `data` into `gpo` at the first rising clock edge of the strobe. Data changes while the same strobe stays low are not written.
- R5: `flash_page` always equals `gpo[2:0]`.
- R6: During an I/O read (`rd_n`=0) with `addr[15]`=1 and `addr[7:3]`=17, `data` carries `status_in`. At all other times the block leaves `data` undriven, so a write placed on the bus lands unchanged.
- R7: Writes to slot 18 load the source indices of interrupts 0 (`data[2:0]`) and 1 (`data[5:3]`). Writes to slot 19 load those of interrupts 2 (`data[2:0]`) and 3 (`data[5:3]`). Both follow the single-write rule of R4.
- R8: `irq_n[k]` equals `ext_irq_n[sel_k]`, where sel_k is the index held at the earlier of two edges, as sampled two rising edges earlier.
- R9: Reset clears `gpo` and all four source indices to zero and drives every `irq_n` high.
- R10: Writes to the input slot, to chip slots, with `io_sel_n` high, or with only `rd_n` low leave `gpo` and the routing unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 16 | Processor address bus |
| io_sel_n | input | 1 | I/O-space select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| data | inout | 8 | Low byte of the processor data bus |
| status_in | input | 8 | External status lines returned on reads |
| ext_irq_n | input | 8 | External interrupt sources, active low |
| cs_n | output | 4 | Peripheral chip strobes, active low |
| flash_rd_n | output | 1 | Flash read strobe, active low |
| flash_wr_n | output | 1 | Flash write strobe, active low |
| flash_page | output | 3 | Flash program-page select |
| gpo | output | 8 | General-purpose output register |
| irq_n | output | 4 | Processor interrupt inputs, active low |

## Verification
Three kinds of result follow from the block's behaviour:

- **Combinational results** are due in the same cycle as the stimulus. These are the chip strobes, the flash strobes and the read data.
- **Register writes** appear one rising edge after the strobe is first seen.
- **Interrupt outputs** change two rising edges after their source or their routing changes.

Inputs are changed on the falling edge and every output is compared three nanoseconds later, just before the next rising edge. The reference model advances its registers and its two-stage interrupt pipeline on each rising edge. It does so in the same order as the requirements: it samples with the old routing first and commits the write afterwards. Each comparison therefore lands in exactly the cycle the requirement fixes.

// File: rtl/bus_glue_pkg.sv
package bus_glue_pkg;

    // Write tracker: one committed write per held write strobe
    typedef enum logic [0:0] {
        WR_IDLE = 1'b0,
        WR_HOLD = 1'b1
    } wr_state_e;

    // Register targeted by a committing write
    typedef enum logic [1:0] {
        TGT_NONE     = 2'd0,
        TGT_OUT      = 2'd1,
        TGT_ROUTE_LO = 2'd2,
        TGT_ROUTE_HI = 2'd3
    } wr_target_e;

endpackage

// File: rtl/bus_glue_decode.sv
module bus_glue_decode #(
    parameter int ADDR_W   = 16,
    parameter int SLOT_LSB = 3,
    parameter int SLOT_W   = 5,
    parameter int NUM_CS   = 4,
    parameter int SLOT_OUT = 16,
    parameter int SLOT_IN  = 17,
    parameter int SLOT_RLO = 18,
    parameter int SLOT_RHI = 19,
    parameter bit HI_MATCH = 1'b1
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              io_sel_n,
    output logic [NUM_CS-1:0] cs_hit,
    output logic              hit_out,
    output logic              hit_in,
    output logic              hit_rlo,
    output logic              hit_rhi
);

    localparam int SLOT_MSB = SLOT_LSB + SLOT_W - 1;

    logic              space_ok;
    logic [SLOT_W-1:0] slot;
    logic              unused_addr_bits;

    assign space_ok = !io_sel_n && (addr[ADDR_W-1] == HI_MATCH);
    assign slot     = addr[SLOT_MSB:SLOT_LSB];

    // Bits below the slot field and between slot and top bit are not decoded
    assign unused_addr_bits = ^{addr[SLOT_LSB-1:0], addr[ADDR_W-2:SLOT_MSB+1]};

    for (genvar i = 0; i < NUM_CS; i++) begin : g_cs
        assign cs_hit[i] = space_ok && (slot == SLOT_W'(i));
    end

    assign hit_out = space_ok && (slot == SLOT_W'(SLOT_OUT));
    assign hit_in  = space_ok && (slot == SLOT_W'(SLOT_IN));
    assign hit_rlo = space_ok && (slot == SLOT_W'(SLOT_RLO));
    assign hit_rhi = space_ok && (slot == SLOT_W'(SLOT_RHI));

endmodule

// File: rtl/bus_glue_regs.sv
module bus_glue_regs
    import bus_glue_pkg::*;
#(
    parameter int DATA_W  = 8,
    parameter int ROUTE_W = 12
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               io_sel_n,
    input  logic               wr_n,
    input  logic               hit_out,
    input  logic               hit_rlo,
    input  logic               hit_rhi,
    input  logic [DATA_W-1:0]  wdata,
    output logic [DATA_W-1:0]  gpo,
    output logic [ROUTE_W-1:0] route
);

    localparam int HALF_W = ROUTE_W / 2;

    wr_state_e  state_q, state_d;
    wr_target_e target;
    logic       wr_act;
    logic       reg_hit;

    assign wr_act  = !io_sel_n && !wr_n;
    assign reg_hit = hit_out || hit_rlo || hit_rhi;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= WR_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions: IDLE->HOLD on a register write, HOLD->IDLE on strobe release
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            WR_IDLE: if (wr_act && reg_hit) state_d = WR_HOLD;
            WR_HOLD: if (!wr_act)           state_d = WR_IDLE;
        endcase
    end

    // Outputs: the IDLE->HOLD transition selects the register to commit
    always_comb begin
        target = TGT_NONE;
        unique case (state_q)
            WR_IDLE: begin
                if (wr_act) begin
                    if (hit_out)      target = TGT_OUT;
                    else if (hit_rlo) target = TGT_ROUTE_LO;
                    else if (hit_rhi) target = TGT_ROUTE_HI;
                end
            end
            WR_HOLD: target = TGT_NONE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gpo   <= '0;
            route <= '0;
        end else begin
            unique case (target)
                TGT_OUT:      gpo                   <= wdata;
                TGT_ROUTE_LO: route[HALF_W-1:0]     <= wdata[HALF_W-1:0];
                TGT_ROUTE_HI: route[ROUTE_W-1:HALF_W] <= wdata[HALF_W-1:0];
                TGT_NONE:     ;
            endcase
        end
    end

endmodule

// File: rtl/bus_glue_irq.sv
module bus_glue_irq #(
    parameter int NUM_SRC     = 8,
    parameter int NUM_IRQ     = 4,
    parameter int SEL_W       = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NUM_SRC-1:0]       src_n,
    input  logic [NUM_IRQ*SEL_W-1:0] route,
    output logic [NUM_IRQ-1:0]       irq_n
);

    for (genvar k = 0; k < NUM_IRQ; k++) begin : g_irq
        logic [SEL_W-1:0]       sel;
        logic                   pick;
        logic [SYNC_STAGES-1:0] stg;

        assign sel  = route[k*SEL_W +: SEL_W];
        assign pick = src_n[sel];

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                stg <= '1;
            end else begin
                stg <= {stg[SYNC_STAGES-2:0], pick};
            end
        end

        assign irq_n[k] = stg[SYNC_STAGES-1];
    end

endmodule

// File: rtl/dsp_bus_glue.sv
module dsp_bus_glue #(
    parameter int ADDR_W      = 16,
    parameter int DATA_W      = 8,
    parameter int NUM_CS      = 4,
    parameter int NUM_SRC     = 8,
    parameter int NUM_IRQ     = 4,
    parameter int PAGE_W      = 3,
    parameter int SYNC_STAGES = 2,
    parameter int SLOT_OUT    = 16,
    parameter int SLOT_IN     = 17,
    parameter int SLOT_RLO    = 18,
    parameter int SLOT_RHI    = 19
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ADDR_W-1:0]  addr,
    input  logic               io_sel_n,
    input  logic               rd_n,
    input  logic               wr_n,
    inout  wire  [DATA_W-1:0]  data,
    input  logic [DATA_W-1:0]  status_in,
    input  logic [NUM_SRC-1:0] ext_irq_n,
    output logic [NUM_CS-1:0]  cs_n,
    output logic               flash_rd_n,
    output logic               flash_wr_n,
    output logic [PAGE_W-1:0]  flash_page,
    output logic [DATA_W-1:0]  gpo,
    output logic [NUM_IRQ-1:0] irq_n
);

    localparam int SEL_W   = $clog2(NUM_SRC);
    localparam int ROUTE_W = NUM_IRQ * SEL_W;

    logic [NUM_CS-1:0]  cs_hit;
    logic               hit_out, hit_in, hit_rlo, hit_rhi;
    logic               drive_en;
    logic [ROUTE_W-1:0] route;

    bus_glue_decode #(
        .ADDR_W  (ADDR_W),
        .NUM_CS  (NUM_CS),
        .SLOT_OUT(SLOT_OUT),
        .SLOT_IN (SLOT_IN),
        .SLOT_RLO(SLOT_RLO),
        .SLOT_RHI(SLOT_RHI)
    ) u_decode (
        .addr    (addr),
        .io_sel_n(io_sel_n),
        .cs_hit  (cs_hit),
        .hit_out (hit_out),
        .hit_in  (hit_in),
        .hit_rlo (hit_rlo),
        .hit_rhi (hit_rhi)
    );

    bus_glue_regs #(
        .DATA_W (DATA_W),
        .ROUTE_W(ROUTE_W)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .io_sel_n(io_sel_n),
        .wr_n    (wr_n),
        .hit_out (hit_out),
        .hit_rlo (hit_rlo),
        .hit_rhi (hit_rhi),
        .wdata   (data),
        .gpo     (gpo),
        .route   (route)
    );

    bus_glue_irq #(
        .NUM_SRC    (NUM_SRC),
        .NUM_IRQ    (NUM_IRQ),
        .SEL_W      (SEL_W),
        .SYNC_STAGES(SYNC_STAGES)
    ) u_irq (
        .clk  (clk),
        .rst_n(rst_n),
        .src_n(ext_irq_n),
        .route(route),
        .irq_n(irq_n)
    );

    assign cs_n       = ~cs_hit;
    assign flash_rd_n = !(cs_hit[0] && !rd_n);
    assign flash_wr_n = !(cs_hit[0] && !wr_n);
    assign flash_page = gpo[PAGE_W-1:0];

    assign drive_en = hit_in && !rd_n;
    assign data     = drive_en ? status_in : {DATA_W{1'bz}};

endmodule

// File: rtl/dsp_bus_glue_checker.sv
module dsp_bus_glue_checker #(
    parameter int NUM_CS  = 4,
    parameter int NUM_SRC = 8,
    parameter int NUM_IRQ = 4,
    parameter int DATA_W  = 8,
    parameter int SEL_W   = 3
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     io_sel_n,
    input logic                     rd_n,
    input logic                     wr_n,
    input logic [NUM_CS-1:0]        cs_n,
    input logic                     flash_rd_n,
    input logic                     flash_wr_n,
    input logic [DATA_W-1:0]        gpo,
    input logic [NUM_IRQ-1:0]       irq_n,
    input logic [NUM_SRC-1:0]       ext_irq_n,
    input logic [NUM_IRQ*SEL_W-1:0] route,
    input logic                     drive_en
);

    logic [1:0] since_rst;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              since_rst <= '0;
        else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
    end

    // R3: no strobe outside I/O space
    a_r3_idle_no_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        io_sel_n |-> (&cs_n && flash_rd_n && flash_wr_n));

    // R2: a flash strobe implies the flash chip strobe
    a_r2_flash_needs_cs: assert property (@(posedge clk) disable iff (!rst_n)
        (!flash_rd_n || !flash_wr_n) |-> !cs_n[0]);

    // R4 / R10: output register holds when no I/O write strobe is present
    a_r4_gpo_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (io_sel_n || wr_n) |=> $stable(gpo));

    // R6: the data bus is driven only inside an I/O read
    a_r6_drive_only_on_read: assert property (@(posedge clk) disable iff (!rst_n)
        drive_en |-> (!io_sel_n && !rd_n));

    // R9: state right after reset release
    a_r9_clear_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (gpo == '0 && route == '0 && &irq_n));

    // R8: with steady routing, each output lags its selected source by two edges
    for (genvar k = 0; k < NUM_IRQ; k++) begin : g_chk
        logic [SEL_W-1:0] sel;
        assign sel = route[k*SEL_W +: SEL_W];

        a_r8_irq_delay: assert property (@(posedge clk) disable iff (!rst_n)
            (since_rst == 2'd3 && $stable(sel) && $past(sel) == $past(sel, 2))
            |-> (irq_n[k] == $past(ext_irq_n[sel], 2)));
    end

endmodule

bind dsp_bus_glue dsp_bus_glue_checker #(
    .NUM_CS (NUM_CS),
    .NUM_SRC(NUM_SRC),
    .NUM_IRQ(NUM_IRQ),
    .DATA_W (DATA_W),
    .SEL_W  (SEL_W)
) u_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .io_sel_n  (io_sel_n),
    .rd_n      (rd_n),
    .wr_n      (wr_n),
    .cs_n      (cs_n),
    .flash_rd_n(flash_rd_n),
    .flash_wr_n(flash_wr_n),
    .gpo       (gpo),
    .irq_n     (irq_n),
    .ext_irq_n (ext_irq_n),
    .route     (route),
    .drive_en  (drive_en)
);

// File: tb/dsp_bus_glue_tb.sv
`timescale 1ns/1ps
module dsp_bus_glue_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] addr = 16'h0000;
    logic        io_sel_n = 1'b1;
    logic        rd_n = 1'b1;
    logic        wr_n = 1'b1;
    logic [7:0]  status_in = 8'h00;
    logic [7:0]  ext_irq_n = 8'hFF;
    logic        tb_drv_en = 1'b0;
    logic [7:0]  tb_drv = 8'h00;
    wire  [7:0]  data;
    logic [3:0]  cs_n;
    logic        flash_rd_n, flash_wr_n;
    logic [2:0]  flash_page;
    logic [7:0]  gpo;
    logic [3:0]  irq_n;

    int n_vec = 0;
    int n_bad = 0;

    assign data = tb_drv_en ? tb_drv : 8'bz;

    always #4 clk = ~clk;

    dsp_bus_glue u_dut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .io_sel_n(io_sel_n),
        .rd_n(rd_n), .wr_n(wr_n), .data(data), .status_in(status_in),
        .ext_irq_n(ext_irq_n), .cs_n(cs_n), .flash_rd_n(flash_rd_n),
        .flash_wr_n(flash_wr_n), .flash_page(flash_page), .gpo(gpo),
        .irq_n(irq_n)
    );

    // ---------------- behavioural reference model ----------------
    logic [7:0] m_gpo;
    int         m_sel[4];
    logic [3:0] m_s1, m_s2;
    bit         m_hold;

    function automatic int slot_of(input logic [15:0] a);
        return (a[15] == 1'b1) ? int'(a[7:3]) : -1;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_gpo = 8'h00;
            foreach (m_sel[k]) m_sel[k] = 0;
            m_s1 = 4'hF; m_s2 = 4'hF;
            m_hold = 1'b0;
        end else begin
            bit wr_act;
            int s;
            m_s2 = m_s1;
            for (int k = 0; k < 4; k++) m_s1[k] = ext_irq_n[m_sel[k]];
            wr_act = !io_sel_n && !wr_n;
            s = slot_of(addr);
            if (m_hold) begin
                m_hold = wr_act;
            end else if (wr_act && (s == 16 || s == 18 || s == 19)) begin
                m_hold = 1'b1;
                if (s == 16) m_gpo = data;
                if (s == 18) begin m_sel[0] = int'(data[2:0]); m_sel[1] = int'(data[5:3]); end
                if (s == 19) begin m_sel[2] = int'(data[2:0]); m_sel[3] = int'(data[5:3]); end
            end
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s at %0t: actual %0h expected %0h", tag, $time, act, exp);
        end
    endtask

    // Compare every cycle, just before the rising edge
    always @(negedge clk) begin
        #3;
        if (rst_n) begin
            logic [3:0] e_cs;
            int s;
            s = slot_of(addr);
            for (int i = 0; i < 4; i++) e_cs[i] = !(!io_sel_n && s == i);
            if (io_sel_n) begin
                check("R3 strobes", {cs_n, flash_rd_n, flash_wr_n}, 6'h3F);
            end else begin
                check("R1 cs_n", cs_n, e_cs);
                check("R2 flash_rd_n", flash_rd_n, !(!e_cs[0] && !rd_n));
                check("R2 flash_wr_n", flash_wr_n, !(!e_cs[0] && !wr_n));
            end
            check("R4 gpo", gpo, m_gpo);
            check("R5 flash_page", flash_page, m_gpo[2:0]);
            check("R8 irq_n", irq_n, m_s2);
            if (!io_sel_n && !rd_n && s == 17) check("R6 read data", data, status_in);
        end
    end

    // ---------------- stimulus ----------------
    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            io_sel_n = 1'b1; rd_n = 1'b1; wr_n = 1'b1; tb_drv_en = 1'b0;
        end
    endtask

    task automatic io_write(input logic [15:0] a, input logic [7:0] d, input int hold);
        @(negedge clk);
        addr = a; tb_drv = d; tb_drv_en = 1'b1; io_sel_n = 1'b0; wr_n = 1'b0;
        for (int i = 1; i < hold; i++) begin
            @(negedge clk);
            tb_drv = ~tb_drv;   // data change inside one strobe
        end
        idle(1);
    endtask

    task automatic io_read(input logic [15:0] a, input int n);
        @(negedge clk);
        addr = a; io_sel_n = 1'b0; rd_n = 1'b0;
        for (int i = 1; i < n; i++) @(negedge clk);
        idle(1);
    endtask

    initial begin
        #(8 * 200000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        #3;
        // R9: reset state
        check("R9 gpo at reset", gpo, 8'h00);
        check("R9 irq_n at reset", irq_n, 4'hF);
        @(negedge clk); rst_n = 1'b1;

        // R3: address and strobes move with I/O space deselected
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            addr = 16'h8000 | 16'(i << 3); rd_n = i[0]; wr_n = !i[0];
        end
        idle(1);

        // R1: every chip slot, noisy low and middle bits, plus top-bit miss
        for (int i = 0; i < 4; i++) io_read(16'h8000 | 16'(i << 3) | 16'h3F05, 2);
        io_read(16'h0008, 2);
        io_read(16'h8020, 2);

        // R2: flash read and write strobes on slot 0
        io_read(16'h8003, 2);
        io_write(16'h8006, 8'h77, 2);

        // R4/R5: one write per held strobe, page select follows
        io_write(16'h8F85, 8'hA5, 4);
        #3 check("R4 single write value", gpo, 8'hA5);
        check("R5 page bits", flash_page, 3'd5);

        // R6: input port read, and release during writes
        status_in = 8'h5A;
        io_read(16'h8088, 3);
        status_in = 8'hC3;
        io_read(16'h808F, 2);
        io_write(16'h8080, 8'h3C, 1);
        #3 check("R6 bus released for write", gpo, 8'h3C);

        // R10: writes that must be ignored
        io_write(16'h8088, 8'hFF, 2);
        io_write(16'h0080, 8'hFF, 2);
        io_write(16'h8000, 8'hFF, 2);
        @(negedge clk); addr = 16'h8080; tb_drv = 8'hFF; tb_drv_en = 1'b1; wr_n = 1'b0;
        idle(1);
        @(negedge clk); addr = 16'h8080; io_sel_n = 1'b0; rd_n = 1'b0;
        idle(2);
        #3 check("R10 gpo unchanged", gpo, 8'h3C);

        // R7/R8: route 0<-6, 1<-3, 2<-1, 3<-7
        io_write(16'h8090, 8'h1E, 2);
        io_write(16'h8098, 8'h39, 2);
        @(negedge clk); ext_irq_n = 8'b1011_1101;
        idle(3);
        #3 check("R7 routed pattern", irq_n, 4'b1010);
        for (int i = 0; i < 8; i++) begin
            @(negedge clk); ext_irq_n = ~(8'h01 << i);
            idle(2);
        end
        @(negedge clk); ext_irq_n = 8'hFF;
        io_write(16'h8090, 8'h3F, 1);
        @(negedge clk); ext_irq_n = 8'h7F;
        idle(4);

        // R9: reset again mid-run
        @(negedge clk); rst_n = 1'b0;
        #3 check("R9 gpo cleared", gpo, 8'h00);
        check("R9 irq_n cleared", irq_n, 4'hF);
        @(negedge clk); rst_n = 1'b1;
        ext_irq_n = 8'hFE;
        idle(4);
        #3 check("R9 routing cleared", irq_n, 4'h0);

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule